// File: doc/BRIEF.md
# Interrupt Pin Dispatcher with Message-Signalled Output

This block collects interrupt requests that arrive as events on numbered input lines. It maps each line onto one of `NUM_PINS` pins and keeps a pending bit for every pin. A priority scan picks one pin at a time and sends it as a 32-bit address / 32-bit data write on a valid/ready port. A separate configuration block owns a per-pin redirection entry, which this block reads as a flat input vector. The end-of-interrupt logic returns per-pin clear strobes.

Each pin is either edge-mode or level-mode. An edge pin sends one message for each accepted request. A level pin sends one message and then stays blocked by its remote-pending bit until an end-of-interrupt clears that bit. The remote-pending bits are visible on an output port.

Top module: `irq_msi_dispatch`

## Requirements
- R1: After reset, no message is valid and every remote-pending bit reads 0.
- R2: An event on line 0 acts on pin 2. A line `n` with 0 < n < NUM_PINS acts on pin n. Events on lines at or above NUM_PINS change nothing.
- R3: On a level-mode pin, an event with level 1 sets the pending bit even if the pin is masked. An event with level 0 clears it. A pin whose pending bit was cleared before it was chosen sends no message.
- R4: On an edge-mode pin, an event with level 1 sets the pending bit only if the entry is unmasked. Requests on a masked edge pin are dropped, and unmasking the pin later sends no message. Events with level 0 are ignored.
- R5: A pin is eligible when it is pending, unmasked, and not (level-mode with remote-pending set). Whenever the output register is free, the lowest-numbered eligible pin is chosen.
- R6: Choosing an edge pin clears its pending bit, so each accepted edge request produces exactly one message.
- R7: Choosing a level pin sets its remote-pending bit one cycle after the event is seen. No further message comes from that pin while the bit is set. A pulse on `eoi_clr_i[p]` clears it, and the pin is sent again if it is still pending. If the set and the clear land in the same cycle, the set wins.
- R8: A pin whose entry is edge-mode has its remote-pending bit forced to 0 on the next clock.
- R9: The message address is 0xFEE00000 | dest<<12 | dest_mode<<2.
- R10: The message data is vector | delivery<<8 | level<<15. Entry layout inside `tbl_i`, per pin p at offset p*30: vector [7:0], delivery [10:8], dest_mode [11], level (1 = level-mode) [12], mask [13], dest [29:14].
- R11: While valid is high and ready is low, address and data hold steady. After a handshake, the next eligible pin is loaded in the same clock, so messages can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Request event strobe |
| ev_line_i | input | LINE_W | Request line number |
| ev_level_i | input | 1 | Request level (1 asserted) |
| tbl_i | input | NUM_PINS*30 | Packed redirection entries |
| eoi_clr_i | input | NUM_PINS | Per-pin remote-pending clear |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |
| rirr_o | output | NUM_PINS | Remote-pending bits |

## Verification
The bench targets the line-0 remap. A design that missed it would send line 0 on pin 0's vector, or send nothing at all. It checks that masked edge requests are dropped, because a design that latched them would send a stray message as soon as the pin is unmasked. Level coalescing is tested across end-of-interrupt pulses. Here a design without the remote-pending block would send a flood of messages, and one that never re-scanned would lose the level that is still asserted. The bench also queues requests behind a stalled receiver. A wrong scan order or a message that changes during the stall then shows up as mismatched address or data, compared against the reference model on every clock.

// File: rtl/irq_msi_pkg.sv
package irq_msi_pkg;
  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        level;
    logic        dmode;
    logic [2:0]  dlv;
    logic [7:0]  vec;
  } rte_t;

  localparam int RTE_W = $bits(rte_t);

  function automatic logic [31:0] msi_addr(rte_t e, logic [31:0] base);
    return base | ({16'd0, e.dest} << 12) | ({31'd0, e.dmode} << 2);
  endfunction

  function automatic logic [31:0] msi_data(rte_t e);
    return {24'd0, e.vec} | ({29'd0, e.dlv} << 8) | ({31'd0, e.level} << 15);
  endfunction
endpackage

// File: rtl/irq_remap.sv
module irq_remap #(
  parameter int NUM_PINS = 24,
  parameter int LINE_W   = 8
) (
  input  logic                ev_valid_i,
  input  logic [LINE_W-1:0]   ev_line_i,
  input  logic                ev_level_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic [NUM_PINS-1:0] set_o,
  output logic [NUM_PINS-1:0] clr_o
);
  localparam logic [LINE_W-1:0] ALIAS_PIN = LINE_W'(2);

  logic [LINE_W-1:0] pin_sel;
  assign pin_sel = (ev_line_i == '0) ? ALIAS_PIN : ev_line_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit;
    assign hit      = ev_valid_i && (pin_sel == LINE_W'(p));
    // level pins latch regardless of mask; edge pins only when unmasked
    assign set_o[p] = hit && ev_level_i && (lvl_i[p] || !mask_i[p]);
    assign clr_o[p] = hit && !ev_level_i && lvl_i[p];
  end
endmodule

// File: rtl/irq_state.sv
module irq_state #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic [NUM_PINS-1:0] sel_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] eoi_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic [NUM_PINS-1:0] rirr_o
);
  logic [NUM_PINS-1:0] pend_q, rirr_q, pend_d, rirr_d;

  always_comb begin
    pend_d = ((pend_q & ~(sel_i & ~lvl_i)) & ~clr_i) | set_i;
    rirr_d = ((rirr_q & ~eoi_i) | (sel_i & lvl_i)) & lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      rirr_q <= '0;
    end else begin
      pend_q <= pend_d;
      rirr_q <= rirr_d;
    end
  end

  assign pend_o = pend_q;
  assign rirr_o = rirr_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] elig_i,
  output logic                any_o,
  output logic [IDX_W-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int p = NUM_PINS - 1; p >= 0; p--) begin
      if (elig_i[p]) idx_o = IDX_W'(p);
    end
  end
  assign any_o = |elig_i;
endmodule

// File: rtl/irq_msi_dispatch.sv
module irq_msi_dispatch
  import irq_msi_pkg::*;
#(
  parameter int          NUM_PINS = 24,
  parameter int          LINE_W   = 8,
  parameter logic [31:0] MSI_BASE = 32'hFEE0_0000,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ev_valid_i,
  input  logic [LINE_W-1:0]         ev_line_i,
  input  logic                      ev_level_i,
  input  logic [NUM_PINS*RTE_W-1:0] tbl_i,
  input  logic [NUM_PINS-1:0]       eoi_clr_i,
  output logic                      msg_valid_o,
  input  logic                      msg_ready_i,
  output logic [31:0]               msg_addr_o,
  output logic [31:0]               msg_data_o,
  output logic [NUM_PINS-1:0]       rirr_o
);
  rte_t                rte [NUM_PINS];
  logic [NUM_PINS-1:0] lvl_vec, mask_vec, set_vec, clr_vec, sel_vec;
  logic [NUM_PINS-1:0] pend, rirr, elig;
  logic                any, fire, vld_q;
  logic [IDX_W-1:0]    idx;
  logic [31:0]         addr_q, data_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_unpack
    assign rte[p]      = rte_t'(tbl_i[p*RTE_W +: RTE_W]);
    assign lvl_vec[p]  = rte[p].level;
    assign mask_vec[p] = rte[p].mask;
    assign sel_vec[p]  = fire && (idx == IDX_W'(p));
  end

  irq_remap #(.NUM_PINS(NUM_PINS), .LINE_W(LINE_W)) u_remap (
    .ev_valid_i(ev_valid_i), .ev_line_i(ev_line_i), .ev_level_i(ev_level_i),
    .lvl_i(lvl_vec), .mask_i(mask_vec), .set_o(set_vec), .clr_o(clr_vec)
  );

  irq_state #(.NUM_PINS(NUM_PINS)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec), .clr_i(clr_vec),
    .sel_i(sel_vec), .lvl_i(lvl_vec), .eoi_i(eoi_clr_i),
    .pend_o(pend), .rirr_o(rirr)
  );

  assign elig = pend & ~mask_vec & ~(lvl_vec & rirr);

  irq_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .elig_i(elig), .any_o(any), .idx_o(idx)
  );

  assign fire = any && (!vld_q || msg_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!vld_q || msg_ready_i) begin
      vld_q <= any;
      if (any) begin
        addr_q <= msi_addr(rte[idx], MSI_BASE);
        data_q <= msi_data(rte[idx]);
      end
    end
  end

  assign msg_valid_o = vld_q;
  assign msg_addr_o  = addr_q;
  assign msg_data_o  = data_q;
  assign rirr_o      = rirr;
endmodule

// File: rtl/irq_msi_chk.sv
module irq_msi_chk #(
  parameter int NUM_PINS = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                msg_valid_i,
  input logic                msg_ready_i,
  input logic [31:0]         msg_addr_i,
  input logic [31:0]         msg_data_i,
  input logic [NUM_PINS-1:0] rirr_i,
  input logic [NUM_PINS-1:0] lvl_i
);
  // R11: held message is stable under backpressure
  a_r11_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && !msg_ready_i |=> msg_valid_i && $stable(msg_addr_i) && $stable(msg_data_i));

  // R9: address carries the fixed base nibble and zero low bits
  a_r9_addr_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i |-> msg_addr_i[31:28] == 4'hF && msg_addr_i[11:3] == '0 && msg_addr_i[1:0] == '0);

  // R10: data has no bits outside vector, delivery and trigger
  a_r10_data_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i |-> msg_data_i[31:16] == '0 && msg_data_i[14:11] == '0);

  // R8: edge-mode entries never keep remote-pending
  a_r8_edge_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (rirr_i & ~$past(lvl_i)) == '0);

  // R7: a new remote-pending bit only appears alongside a loaded message
  a_r7_set_on_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rirr_i & ~$past(rirr_i)) != '0 |-> msg_valid_i);
endmodule

bind irq_msi_dispatch irq_msi_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_valid_i(msg_valid_o), .msg_ready_i(msg_ready_i),
  .msg_addr_i(msg_addr_o), .msg_data_i(msg_data_o), .rirr_i(rirr_o), .lvl_i(lvl_vec)
);

// File: tb/sim_irq_msi_dispatch.sv
`timescale 1ns/1ps
module sim_irq_msi_dispatch;
  localparam int NP = 24;
  localparam int LW = 8;
  localparam int EW = 30;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_level = 0, ready = 1;
  logic [LW-1:0] ev_line = '0;
  logic [NP*EW-1:0] tbl;
  logic [NP-1:0] eoi = '0;
  logic m_valid;
  logic [31:0] m_addr, m_data;
  logic [NP-1:0] rirr;

  logic [7:0]  t_vec [NP];
  logic [2:0]  t_dlv [NP];
  logic        t_dm  [NP];
  logic        t_lvl [NP];
  logic        t_msk [NP];
  logic [15:0] t_dst [NP];

  always #2.5 clk = ~clk;

  always_comb
    for (int p = 0; p < NP; p++)
      tbl[p*EW +: EW] = {t_dst[p], t_msk[p], t_lvl[p], t_dm[p], t_dlv[p], t_vec[p]};

  irq_msi_dispatch u0 (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_line_i(ev_line),
    .ev_level_i(ev_level), .tbl_i(tbl), .eoi_clr_i(eoi), .msg_valid_o(m_valid),
    .msg_ready_i(ready), .msg_addr_o(m_addr), .msg_data_o(m_data), .rirr_o(rirr)
  );

  // reference model
  bit pend_m [NP];
  bit rirr_m [NP];
  bit mv;
  logic [31:0] ma, md;
  int sent;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin pend_m[p] = 0; rirr_m[p] = 0; end
      mv = 0; ma = 0; md = 0; sent = 0;
    end else begin
      int sel;
      sel = -1;
      if (mv && ready) sent++;
      if (!mv || ready) begin
        for (int p = NP - 1; p >= 0; p--)
          if (pend_m[p] && !t_msk[p] && !(t_lvl[p] && rirr_m[p])) sel = p;
        mv = (sel >= 0);
        if (sel >= 0) begin
          ma = 32'hFEE00000 | (32'(t_dst[sel]) << 12) | (32'(t_dm[sel]) << 2);
          md = 32'(t_vec[sel]) | (32'(t_dlv[sel]) << 8) | (32'(t_lvl[sel]) << 15);
        end
      end
      if (sel >= 0 && !t_lvl[sel]) pend_m[sel] = 0;
      if (ev_valid) begin
        int pin;
        pin = (ev_line == 0) ? 2 : int'(ev_line);
        if (pin < NP) begin
          if (t_lvl[pin]) pend_m[pin] = ev_level;
          else if (ev_level && !t_msk[pin]) pend_m[pin] = 1;
        end
      end
      for (int p = 0; p < NP; p++) begin
        if (eoi[p]) rirr_m[p] = 0;
        if (sel == p && t_lvl[p]) rirr_m[p] = 1;
        if (!t_lvl[p]) rirr_m[p] = 0;
      end
    end
  end

  int vecs = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always @(negedge clk) if (rst_n && !done) begin
    logic [NP-1:0] rexp;
    for (int p = 0; p < NP; p++) rexp[p] = rirr_m[p];
    vecs++;
    if (m_valid !== mv || (mv && (m_addr !== ma || m_data !== md)) || rirr !== rexp) begin
      bad++;
      $display("FAIL %s: valid=%0b addr=%h data=%h rirr=%h, expected valid=%0b addr=%h data=%h rirr=%h",
               cur_req, m_valid, m_addr, m_data, rirr, mv, ma, md, rexp);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ev(input int line, input bit lvl);
    @(negedge clk);
    ev_valid = 1; ev_line = LW'(line); ev_level = lvl;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic pulse_eoi(input int p);
    @(negedge clk); eoi[p] = 1;
    @(negedge clk); eoi = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int s0;
    for (int p = 0; p < NP; p++) begin
      t_vec[p] = 8'(8'h20 + p); t_dlv[p] = 3'(p); t_dm[p] = p[0];
      t_lvl[p] = 0; t_msk[p] = 0; t_dst[p] = 16'(p * 3);
    end
    cyc(3); rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check(m_valid == 0, "R1", 32'(m_valid), 0);
    check(rirr == '0, "R1", 32'(rirr), 0);

    // R9 / R10 formats
    cur_req = "R9";
    t_dst[5] = 16'h0012; t_dm[5] = 1; t_dlv[5] = 3; t_vec[5] = 8'h35;
    ev(5, 1); @(negedge clk);
    check(m_addr == 32'hFEE12004, "R9", m_addr, 32'hFEE12004);
    check(m_data == 32'h00000335, "R10", m_data, 32'h335);
    cyc(3);

    // R2 remap and out-of-range lines
    cur_req = "R2";
    s0 = sent;
    ev(0, 1); @(negedge clk);
    check(m_valid && m_data[7:0] == t_vec[2], "R2", m_data, 32'(t_vec[2]));
    ev(30, 1); ev(24, 1); ev(200, 1); cyc(4);
    check(sent == s0 + 1, "R2", sent, s0 + 1);

    // R4 masked edge dropped, low level ignored
    cur_req = "R4";
    s0 = sent;
    t_msk[7] = 1; ev(7, 1); cyc(2); t_msk[7] = 0; cyc(4);
    ev(8, 0); cyc(4);
    check(sent == s0, "R4", sent, s0);

    // R5 / R11 / R6 priority under backpressure
    cur_req = "R11";
    @(negedge clk) ready = 0;
    ev(12, 1); ev(9, 1); ev(4, 1); ev(6, 1); ev(4, 1);
    cyc(5);
    check(m_data[7:0] == t_vec[12], "R11", m_data, 32'(t_vec[12]));
    cur_req = "R5";
    s0 = sent;
    @(negedge clk) ready = 1;
    cyc(8);
    check(sent == s0 + 4, "R6", sent, s0 + 4);

    // R7 level coalescing
    cur_req = "R7";
    t_lvl[10] = 1; t_vec[10] = 8'h51; t_dlv[10] = 1;
    s0 = sent;
    ev(10, 1); @(negedge clk);
    check(rirr[10] == 1, "R7", 32'(rirr[10]), 1);
    cyc(6);
    check(sent == s0 + 1, "R7", sent, s0 + 1);
    pulse_eoi(10); cyc(4);
    check(sent == s0 + 2, "R7", sent, s0 + 2);
    cur_req = "R3";
    ev(10, 0); pulse_eoi(10); cyc(4);
    check(sent == s0 + 2 && rirr[10] == 0, "R3", sent, s0 + 2);

    // R3 masked level cleared before unmask
    t_lvl[14] = 1; t_msk[14] = 1;
    s0 = sent;
    ev(14, 1); cyc(2); ev(14, 0); t_msk[14] = 0; cyc(5);
    check(sent == s0, "R3", sent, s0);

    // R8 switching a held level pin to edge
    cur_req = "R8";
    ev(10, 1); cyc(3);
    check(rirr[10] == 1, "R7", 32'(rirr[10]), 1);
    @(negedge clk) t_lvl[10] = 0;
    @(negedge clk);
    check(rirr[10] == 0, "R8", 32'(rirr[10]), 0);
    cyc(6);

    // stall with several level and edge pins, then random-ish ready
    cur_req = "R11";
    t_lvl[3] = 1;
    ev(3, 1); ev(1, 1); ev(20, 1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk) ready = ((i % 3) != 0);
      if (i == 20) eoi[3] = 1; else eoi = '0;
    end
    ready = 1; cyc(6);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule